// File: doc/BRIEF.md
# Shadow-Register Interrupt Controller

This block adds interrupt handling to a small 32-bit RISC-V-style core. It does not use standard CSRs. The core passes it each instruction word together with the rs1 operand and the current PC. The block decodes a small family of custom R-type instructions in the custom0 opcode slot and answers in the same cycle: an rd write-back, a PC redirect or a stall. It holds four shadow registers (q0 to q3), an interrupt mask, a pending register that captures rising request edges, and a delivery-enable flag.

When delivery is enabled and an unmasked interrupt is pending, the block redirects the core to the interrupt vector. The vector sits 16 bytes above the reset address. At entry the block saves the interrupted PC in q0 and the serviced bitmask in q1, removes those bits from pending, and turns delivery off. Delivery stays off until the return instruction runs, so handlers never nest.

The controller has two named states. **RUN** executes instructions and checks for interrupt entry. **WAIT** holds the core stalled after a wait instruction found nothing pending. The transitions are:

- **RUN→WAIT**: a wait instruction runs while the pending register is empty.
- **WAIT→RUN**: any pending bit is set. The wait instruction then completes.
- **RUN→RUN**: every other case, including interrupt entry and return.

Top module: `irq_shadow_ctl`

## Requirements
- R1: After reset, q0 to q3 read 0, the mask is all ones (every line blocked), pending is empty, delivery is enabled, and rd_we, pc_redirect, stall and illegal are all 0.
- R2: Only a word with instr_valid=1 and opcode bits [6:0]=0001011 is acted on. Its fields are funct7[31:25], rs2[24:20], rs1[19:15], funct3[14:12] and rd[11:7]. Any other word, or a word with instr_valid=0, has no effect.
- R3: Shadow read (funct7=0000000, funct3=100) drives rd_we=1 in the same cycle. rd_wdata carries the shadow register that the rs1 field selects (0 to 3).
- R4: Shadow write (funct7=0000001, funct3=010) loads rs1_val into the shadow register that the rd field selects. The new value can be read from the next cycle.
- R5: Return (funct7=0000010, funct3=000) drives pc_redirect=1 with pc_target=q0 in the same cycle. Delivery is enabled again from the next cycle.
- R6: Mask swap (funct7=0000011, funct3=110) returns the old mask on rd_wdata with rd_we=1 in the same cycle. It loads the mask from rs1_val for the next cycle.
- R7: Wait (funct7=0000100, funct3=100) completes at once when any pending bit is set, masked or not, writing the pending bitmask to rd. Otherwise it holds stall=1 (with rd_we=0) until a bit becomes pending, then writes that bitmask. Wait does not clear pending.
- R8: A 0-to-1 transition on irq_req[i] sets pending bit i one cycle later. The bit stays set until interrupt entry services it.
- R9: In RUN, with delivery enabled and (pending AND NOT mask) nonzero, the block drives pc_redirect=1 with pc_target = reset address + 0x10. Any instruction presented in that cycle is discarded, and rd_we is never 1 together with pc_redirect.
- R10: At entry, q0 receives pc_cur, q1 receives the serviced bits (pending AND NOT mask), those bits leave pending, and delivery is disabled.
- R11: While delivery is disabled, no entry happens, however many unmasked bits are pending.
- R12: A custom0 word is illegal in any of these cases: its funct7/funct3 pair is not one of the five above, its rs2 field is nonzero, or a shadow index is 4 or more. An illegal word drives illegal=1 for that cycle and changes no state.
- R13: A mask bit of 1 blocks its line from entry, but the line still latches into pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_valid | input | 1 | instr holds an instruction to execute |
| instr | input | 32 | Instruction word |
| rs1_val | input | 32 | Value of the rs1 general register |
| pc_cur | input | 32 | PC of the presented or next instruction |
| irq_req | input | 32 | Interrupt request lines |
| rd_we | output | 1 | Write rd_wdata to general register rd_idx |
| rd_idx | output | 5 | Destination register field |
| rd_wdata | output | 32 | Write-back value |
| pc_redirect | output | 1 | Core must fetch from pc_target |
| pc_target | output | 32 | Redirect address |
| stall | output | 1 | Core holds the current instruction |
| illegal | output | 1 | Unrecognised custom0 encoding |

## Verification
Interrupt entry is the hardest behaviour to reach from the ports. It needs a latched edge, an unmasked bit and enabled delivery all at once. Entry also erases the evidence in pending, and it is hard to reach again while a handler is still active.

The stimulus first latches a request under a fully blocking mask and confirms it through a non-blocking wait. It then unmasks the line with a mask swap, so that entry fires on the very next cycle. A shadow write is presented in that same cycle to show that the instruction is discarded. A second request raised inside the handler proves there is no nesting: it must stay pending until the return instruction, and entry must then follow on the cycle right after the return.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam logic [6:0] OPC_CUSTOM0 = 7'b0001011;

    localparam logic [9:0] KEY_QREAD    = {7'b0000000, 3'b100};
    localparam logic [9:0] KEY_QWRITE   = {7'b0000001, 3'b010};
    localparam logic [9:0] KEY_RETURN   = {7'b0000010, 3'b000};
    localparam logic [9:0] KEY_MASKSWAP = {7'b0000011, 3'b110};
    localparam logic [9:0] KEY_WAIT     = {7'b0000100, 3'b100};

    typedef enum logic [2:0] {
        OP_NONE,
        OP_QREAD,
        OP_QWRITE,
        OP_RETURN,
        OP_MASKSWAP,
        OP_WAIT,
        OP_BAD
    } irqc_op_e;

    typedef enum logic {
        ST_RUN,
        ST_WAIT
    } irqc_state_e;
endpackage

// File: rtl/irqc_decode.sv
module irqc_decode
    import irqc_pkg::*;
#(
    parameter int NQ = 4
) (
    input  logic        instr_valid,
    input  logic [31:0] instr,
    output irqc_op_e    op,
    output logic [4:0]  rd_f,
    output logic [4:0]  rs1_f
);
    logic [9:0] key;
    logic       rs2_zero;
    logic       rs1_in_range;
    logic       rd_in_range;

    assign key          = {instr[31:25], instr[14:12]};
    assign rs2_zero     = (instr[24:20] == 5'd0);
    assign rs1_f        = instr[19:15];
    assign rd_f         = instr[11:7];
    assign rs1_in_range = (32'(rs1_f) < NQ);
    assign rd_in_range  = (32'(rd_f) < NQ);

    always_comb begin
        op = OP_NONE;
        if (instr_valid && instr[6:0] == OPC_CUSTOM0) begin
            if (!rs2_zero) begin
                op = OP_BAD;
            end else begin
                unique case (key)
                    KEY_QREAD:    op = rs1_in_range ? OP_QREAD  : OP_BAD;
                    KEY_QWRITE:   op = rd_in_range  ? OP_QWRITE : OP_BAD;
                    KEY_RETURN:   op = OP_RETURN;
                    KEY_MASKSWAP: op = OP_MASKSWAP;
                    KEY_WAIT:     op = OP_WAIT;
                    default:      op = OP_BAD;
                endcase
            end
        end
    end
endmodule

// File: rtl/irqc_pending.sv
module irqc_pending #(
    parameter int NIRQ = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NIRQ-1:0] irq_req,
    input  logic [NIRQ-1:0] clr_bits,
    output logic [NIRQ-1:0] pend
);
    logic [NIRQ-1:0] req_prev;
    logic [NIRQ-1:0] rise;

    assign rise = irq_req & ~req_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_prev <= '0;
            pend     <= '0;
        end else begin
            req_prev <= irq_req;
            pend     <= (pend & ~clr_bits) | rise;
        end
    end

    AST_EDGE_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        (rise != '0) |=> ((pend & $past(rise)) == $past(rise))); // R8
endmodule

// File: rtl/irq_shadow_ctl.sv
module irq_shadow_ctl
    import irqc_pkg::*;
#(
    parameter int               XLEN       = 32,
    parameter int               NIRQ       = 32,
    parameter int               NQ         = 4,
    parameter logic [XLEN-1:0]  RESET_ADDR = '0,
    parameter int               VEC_OFFSET = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            instr_valid,
    input  logic [31:0]     instr,
    input  logic [XLEN-1:0] rs1_val,
    input  logic [XLEN-1:0] pc_cur,
    input  logic [NIRQ-1:0] irq_req,
    output logic            rd_we,
    output logic [4:0]      rd_idx,
    output logic [XLEN-1:0] rd_wdata,
    output logic            pc_redirect,
    output logic [XLEN-1:0] pc_target,
    output logic            stall,
    output logic            illegal
);
    localparam int              QW       = $clog2(NQ);
    localparam logic [XLEN-1:0] VEC_ADDR = RESET_ADDR + XLEN'(VEC_OFFSET);

    irqc_state_e     st_r, st_n;
    irqc_op_e        op, exec_op;
    logic [4:0]      rd_f, rs1_f;
    logic [NIRQ-1:0] pend_vec, avail, clr_bits, mask_r;
    logic            irq_en_r, take_irq, any_pend;
    logic [XLEN-1:0] q_r [NQ];

    irqc_decode #(.NQ(NQ)) u_decode (
        .instr_valid (instr_valid),
        .instr       (instr),
        .op          (op),
        .rd_f        (rd_f),
        .rs1_f       (rs1_f)
    );

    irqc_pending #(.NIRQ(NIRQ)) u_pending (
        .clk      (clk),
        .rst_n    (rst_n),
        .irq_req  (irq_req),
        .clr_bits (clr_bits),
        .pend     (pend_vec)
    );

    assign any_pend = (pend_vec != '0);
    assign avail    = pend_vec & ~mask_r;
    assign take_irq = (st_r == ST_RUN) && irq_en_r && (avail != '0);
    assign exec_op  = (st_r == ST_RUN && !take_irq) ? op : OP_NONE;
    assign clr_bits = take_irq ? avail : '0;
    assign rd_idx   = rd_f;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_r <= ST_RUN;
        else        st_r <= st_n;
    end

    // next state and outputs
    always_comb begin
        st_n        = st_r;
        rd_we       = 1'b0;
        rd_wdata    = '0;
        pc_redirect = 1'b0;
        pc_target   = '0;
        stall       = 1'b0;
        illegal     = 1'b0;
        unique case (st_r)
            ST_RUN: begin
                if (take_irq) begin
                    pc_redirect = 1'b1;
                    pc_target   = VEC_ADDR;
                end else begin
                    unique case (exec_op)
                        OP_QREAD: begin
                            rd_we    = 1'b1;
                            rd_wdata = q_r[rs1_f[QW-1:0]];
                        end
                        OP_RETURN: begin
                            pc_redirect = 1'b1;
                            pc_target   = q_r[0];
                        end
                        OP_MASKSWAP: begin
                            rd_we    = 1'b1;
                            rd_wdata = XLEN'(mask_r);
                        end
                        OP_WAIT: begin
                            if (any_pend) begin
                                rd_we    = 1'b1;
                                rd_wdata = XLEN'(pend_vec);
                            end else begin
                                stall = 1'b1;
                                st_n  = ST_WAIT;
                            end
                        end
                        OP_BAD:  illegal = 1'b1;
                        default: ;
                    endcase
                end
            end
            ST_WAIT: begin
                if (any_pend) begin
                    rd_we    = 1'b1;
                    rd_wdata = XLEN'(pend_vec);
                    st_n     = ST_RUN;
                end else begin
                    stall = 1'b1;
                end
            end
            default: st_n = ST_RUN;
        endcase
    end

    // mask and delivery flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_r   <= '1;
            irq_en_r <= 1'b1;
        end else begin
            if (take_irq)                   irq_en_r <= 1'b0;
            else if (exec_op == OP_RETURN)  irq_en_r <= 1'b1;
            if (exec_op == OP_MASKSWAP)     mask_r   <= rs1_val[NIRQ-1:0];
        end
    end

    // shadow registers
    for (genvar gi = 0; gi < NQ; gi++) begin : g_shadow
        logic [XLEN-1:0] entry_val;
        if (gi == 0)      begin : g_pc   assign entry_val = pc_cur;       end
        else if (gi == 1) begin : g_bits assign entry_val = XLEN'(avail); end
        else              begin : g_keep assign entry_val = q_r[gi];      end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                q_r[gi] <= '0;
            else if (take_irq)
                q_r[gi] <= entry_val;
            else if (exec_op == OP_QWRITE && 32'(rd_f[QW-1:0]) == gi)
                q_r[gi] <= rs1_val;
        end
    end

    AST_ENTRY_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |=> !irq_en_r); // R10
    AST_NO_REENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en_r |-> !(pc_redirect && pc_target == VEC_ADDR && exec_op == OP_NONE && st_r == ST_RUN && instr_valid == 1'b0)); // R11
    AST_RETURN_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_op == OP_RETURN) |=> irq_en_r); // R5
    AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_we && pc_redirect)); // R9
    AST_STALL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (!rd_we && !pc_redirect)); // R7
    AST_BAD_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |=> ($stable(mask_r) && $stable(irq_en_r) && $stable(q_r[0]) && $stable(q_r[1]))); // R12
endmodule

// File: tb/irq_shadow_ctl_tb_top.sv
`timescale 1ns/1ps
module irq_shadow_ctl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] rs1_val = '0;
    logic [31:0] pc_cur = 32'h100;
    logic [31:0] irq_req = '0;
    logic        rd_we, pc_redirect, stall, illegal;
    logic [4:0]  rd_idx;
    logic [31:0] rd_wdata, pc_target;

    int total = 0;
    int bad = 0;

    logic        s_we, s_redir, s_stall, s_ill;
    logic [31:0] s_wdata, s_target;

    always #2.5 clk = ~clk;

    irq_shadow_ctl dut_i (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
        .rs1_val(rs1_val), .pc_cur(pc_cur), .irq_req(irq_req),
        .rd_we(rd_we), .rd_idx(rd_idx), .rd_wdata(rd_wdata),
        .pc_redirect(pc_redirect), .pc_target(pc_target),
        .stall(stall), .illegal(illegal)
    );

    function automatic logic [31:0] enc(input logic [6:0] f7, input logic [4:0] rs1f,
                                        input logic [2:0] f3, input logic [4:0] rdf);
        return {f7, 5'd0, rs1f, f3, rdf, 7'b0001011};
    endfunction

    function automatic logic [31:0] i_qread(input logic [4:0] q, input logic [4:0] rd);
        return enc(7'b0000000, q, 3'b100, rd);
    endfunction
    function automatic logic [31:0] i_qwrite(input logic [4:0] q);
        return enc(7'b0000001, 5'd10, 3'b010, q);
    endfunction
    function automatic logic [31:0] i_ret();
        return enc(7'b0000010, 5'd0, 3'b000, 5'd0);
    endfunction
    function automatic logic [31:0] i_mask();
        return enc(7'b0000011, 5'd11, 3'b110, 5'd12);
    endfunction
    function automatic logic [31:0] i_wait();
        return enc(7'b0000100, 5'd0, 3'b100, 5'd13);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic capture();
        s_we = rd_we; s_redir = pc_redirect; s_stall = stall;
        s_ill = illegal; s_wdata = rd_wdata; s_target = pc_target;
    endtask

    // present one instruction for one cycle
    task automatic issue(input logic [31:0] ins, input logic [31:0] r1);
        @(negedge clk);
        instr = ins; rs1_val = r1; instr_valid = 1'b1;
        #1 capture();
        @(posedge clk);
        #1 instr_valid = 1'b0;
    endtask

    task automatic idle_cycle();
        @(negedge clk);
        #1 capture();
        @(posedge clk);
    endtask

    task automatic pulse(input int b);
        @(negedge clk) irq_req[b] = 1'b1;
        @(negedge clk) irq_req[b] = 1'b0;
    endtask

    task automatic t_reset();
        idle_cycle();
        chk("R1 rd_we", 32'(s_we), 0);
        chk("R1 redirect", 32'(s_redir), 0);
        chk("R1 stall", 32'(s_stall), 0);
        chk("R1 illegal", 32'(s_ill), 0);
        for (int q = 0; q < 4; q++) begin
            issue(i_qread(5'(q), 5'd5), 0);
            chk("R1 R3 shadow reset", s_wdata, 0);
        end
        issue(i_mask(), 32'hFFFF_FFFF);
        chk("R1 R6 mask reset", s_wdata, 32'hFFFF_FFFF);
    endtask

    task automatic t_shadow();
        for (int q = 0; q < 4; q++) issue(i_qwrite(5'(q)), 32'hA5A5_0000 + 32'(q));
        for (int q = 0; q < 4; q++) begin
            issue(i_qread(5'(q), 5'd7), 0);
            chk("R3 rd_we", 32'(s_we), 1);
            chk("R4 shadow value", s_wdata, 32'hA5A5_0000 + 32'(q));
        end
    endtask

    task automatic t_maskswap();
        issue(i_mask(), 32'h0000_00F0);
        chk("R6 old mask", s_wdata, 32'hFFFF_FFFF);
        issue(i_mask(), 32'hFFFF_FFFF);
        chk("R6 swapped mask", s_wdata, 32'h0000_00F0);
    endtask

    task automatic t_wait_masked();
        pulse(5);
        issue(i_wait(), 0);
        chk("R7 R13 no stall", 32'(s_stall), 0);
        chk("R13 masked not taken", 32'(s_redir), 0);
        chk("R7 R8 pending bits", s_wdata, 32'h20);
    endtask

    task automatic t_entry();
        issue(i_mask(), ~32'h20);
        chk("R6 unmask read", s_wdata, 32'hFFFF_FFFF);
        pc_cur = 32'h200;
        issue(i_qwrite(5'd3), 32'hDEAD_BEEF);
        chk("R9 redirect", 32'(s_redir), 1);
        chk("R9 vector", s_target, 32'h10);
        chk("R9 no write", 32'(s_we), 0);
        issue(i_qread(5'd3, 5'd1), 0);
        chk("R9 squashed write", s_wdata, 32'hA5A5_0003);
        issue(i_qread(5'd0, 5'd1), 0);
        chk("R10 q0 pc", s_wdata, 32'h200);
        issue(i_qread(5'd1, 5'd1), 0);
        chk("R10 q1 cause", s_wdata, 32'h20);
    endtask

    task automatic t_no_nest();
        pulse(5);
        for (int k = 0; k < 3; k++) begin
            idle_cycle();
            chk("R11 no nested entry", 32'(s_redir), 0);
        end
        issue(i_wait(), 0);
        chk("R11 still pending", s_wdata, 32'h20);
        pc_cur = 32'h300;
        issue(i_ret(), 0);
        chk("R5 redirect", 32'(s_redir), 1);
        chk("R5 target q0", s_target, 32'h200);
        idle_cycle();
        chk("R5 R11 entry after return", 32'(s_redir), 1);
        chk("R5 vector", s_target, 32'h10);
        issue(i_qread(5'd0, 5'd1), 0);
        chk("R10 q0 second entry", s_wdata, 32'h300);
        issue(i_mask(), 32'hFFFF_FFFF);
        issue(i_ret(), 0);
        chk("R5 second return", s_target, 32'h300);
        idle_cycle();
        chk("R10 pending cleared", 32'(s_redir), 0);
    endtask

    task automatic t_wait_stall();
        @(negedge clk);
        instr = i_wait(); instr_valid = 1'b1;
        #1 chk("R7 stall start", 32'(stall), 1);
        chk("R7 no write while stalled", 32'(rd_we), 0);
        @(posedge clk);
        @(negedge clk) irq_req[3] = 1'b1;
        #1 chk("R7 still stalled", 32'(stall), 1);
        @(posedge clk);
        @(negedge clk) irq_req[3] = 1'b0;
        #1 chk("R7 release", 32'(stall), 0);
        chk("R7 R8 wait result", rd_wdata, 32'h8);
        chk("R7 write", 32'(rd_we), 1);
        @(posedge clk);
        #1 instr_valid = 1'b0;
        issue(i_wait(), 0);
        chk("R7 not cleared", s_wdata, 32'h8);
    endtask

    task automatic t_illegal();
        issue(enc(7'b0000101, 5'd0, 3'b000, 5'd2), 32'h1234);
        chk("R12 flag", 32'(s_ill), 1);
        chk("R12 no write", 32'(s_we), 0);
        issue({7'b0000001, 5'd1, 5'd10, 3'b010, 5'd2, 7'b0001011}, 32'h1234);
        chk("R12 rs2 flag", 32'(s_ill), 1);
        issue(enc(7'b0000001, 5'd10, 3'b010, 5'd6), 32'h1234);
        chk("R12 index flag", 32'(s_ill), 1);
        issue(i_qread(5'd2, 5'd1), 0);
        chk("R12 shadow kept", s_wdata, 32'hA5A5_0002);
        issue({i_qread(5'd2, 5'd1)} & ~32'h7F | 32'h33, 0);
        chk("R2 other opcode", 32'(s_we), 0);
        chk("R2 other opcode not illegal", 32'(s_ill), 0);
        @(negedge clk);
        instr = i_qread(5'd2, 5'd1); instr_valid = 1'b0;
        #1 chk("R2 invalid ignored", 32'(rd_we), 0);
        @(posedge clk);
        issue(i_mask(), 32'hFFFF_FFFF);
        chk("R12 mask kept", s_wdata, 32'hFFFF_FFFF);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_shadow();
        t_maskswap();
        t_wait_masked();
        t_entry();
        t_no_nest();
        t_wait_stall();
        t_illegal();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule